// File: doc/BRIEF.md
# Staged Power Domain Wake Sequencer

This block drives the enable lines of three switchable supply domains in a low-power non-volatile memory. The domains are an I/O domain that feeds the serial interface, a core domain that feeds the read path and the digital logic, and a high-voltage write domain. The block moves the device between three power modes. In deep power-down every domain is off, and only the externally supplied reset detector stays alive. In regular standby only the I/O domain is on. In the awake mode the I/O and core domains are on, and the write domain is added while a write is pending.

On the way up the block enables one domain per step, in the order I/O, core, write. After each step it waits a programmable number of settle cycles before it takes the next step, which keeps in-rush current low. On the way down it removes one domain per cycle in the reverse order. The sequencer finishes any settle window that is running before it changes direction. The ready flag asserts only when the device is awake, every domain it needs is on, and the last step has settled. A command that arrives while the flag is low is rejected.

Top module: `pwr_wake_seq`

## Requirements
- R1: While reset is asserted and after it is released, all three enables are 0, ready_o is 0 and cmd_rej_o is 0. This is the deep power-down mode.
- R2: With settle count N and wr_pend_i low, a wake request in deep power-down raises io_en_o one cycle after the request edge. core_en_o rises N+1 cycles after io_en_o. ready_o rises N cycles after core_en_o.
- R3: Between any two consecutive clock cycles, at most one of the three enables changes.
- R4: The enables stay prefix-ordered: core_en_o is 1 only while io_en_o is 1, and wr_en_o is 1 only while core_en_o is 1.
- R5: ready_o is 1 only in the awake mode, with io_en_o and core_en_o at 1, with wr_en_o equal to wr_pend_i, and with no settle window running.
- R6: While the device is awake, a high wr_pend_i turns on wr_en_o at the next edge and ready_o returns N cycles later. A low wr_pend_i turns off wr_en_o at the next edge. No other input turns the write domain on.
- R7: A deep power-down request (pd_req_i=1, pd_deep_i=1) turns the enables off one per cycle in the order write, core, I/O. The first one drops one cycle after the mode change, and all three end at 0.
- R8: A light power-down request (pd_req_i=1, pd_deep_i=0) from the awake mode drops the write and core domains and leaves io_en_o at 1 with ready_o at 0. This is regular standby.
- R9: A power-down request that arrives while a settle window is running changes no enable until that window has expired.
- R10: cmd_rej_o is 1 in the cycle after cmd_i was high while ready_o was low. Otherwise it is 0.
- R11: When pd_req_i and wake_req_i are high in the same cycle, the power-down request wins.
- R12: A wake request in regular standby raises core_en_o at the next edge without a further I/O step. ready_o follows N+1 cycles after the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_req_i | input | 1 | Power-down command |
| pd_deep_i | input | 1 | With pd_req_i: 1 selects deep power-down, 0 selects regular standby |
| wake_req_i | input | 1 | Wake request, moves the device to the awake mode |
| wr_pend_i | input | 1 | A write is pending, so the write domain is needed |
| settle_cyc_i | input | CNT_W | Settle cycles that follow each enable step |
| cmd_i | input | 1 | Memory command strobe |
| io_en_o | output | 1 | I/O domain enable |
| core_en_o | output | 1 | Core domain enable |
| wr_en_o | output | 1 | Write domain enable |
| ready_o | output | 1 | All required domains are on and settled |
| cmd_rej_o | output | 1 | The command of the previous cycle was rejected |

## Verification
Four properties are checked on every cycle: the prefix ordering of the enables, the limit of one enable change per cycle, that no enable moves while a settle window is running, and the consistency of ready and reject with the enables. Only the bench's scenarios can show the exact step spacing of N+1 cycles and the exact ready latency. The same holds for the reverse shutdown order, for a light power-down leaving the I/O domain on, for power-down winning over wake, and for a power-down during wake waiting out the current settle window.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int NUM_DOM  = 3;
  localparam int DOM_IO   = 0;
  localparam int DOM_CORE = 1;
  localparam int DOM_WR   = 2;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_STBY = 2'd1,
    MODE_ON   = 2'd2
  } pwr_mode_e;
endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             idle_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_i)          cnt_d = load_val_i;
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign idle_o = (cnt_q == '0);

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> idle_o); // R9
  AST_LOAD_OPENS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i != '0) |=> !idle_o); // R2
endmodule

// File: rtl/pwr_step_sel.sv
module pwr_step_sel #(
  parameter int N = 3
) (
  input  logic         go_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] tgt_i,
  output logic [N-1:0] en_nxt_o,
  output logic         load_o
);
  logic found;

  // Shutdown first: drop the highest live domain; otherwise raise the lowest missing one.
  always_comb begin
    en_nxt_o = en_i;
    load_o   = 1'b0;
    found    = 1'b0;
    if (go_i) begin
      if (|(en_i & ~tgt_i)) begin
        for (int i = N-1; i >= 0; i--) begin
          if (!found && en_i[i]) begin
            en_nxt_o[i] = 1'b0;
            found       = 1'b1;
          end
        end
      end else if (|(tgt_i & ~en_i)) begin
        for (int i = 0; i < N; i++) begin
          if (!found && tgt_i[i] && !en_i[i]) begin
            en_nxt_o[i] = 1'b1;
            load_o      = 1'b1;
            found       = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_req_i,
  input  logic             pd_deep_i,
  input  logic             wake_req_i,
  input  logic             wr_pend_i,
  input  logic [CNT_W-1:0] settle_cyc_i,
  input  logic             cmd_i,
  output logic             io_en_o,
  output logic             core_en_o,
  output logic             wr_en_o,
  output logic             ready_o,
  output logic             cmd_rej_o
);
  pwr_mode_e          mode_q, mode_d;
  logic [NUM_DOM-1:0] en_q, en_d, tgt;
  logic               idle, load;

  always_comb begin
    mode_d = mode_q;
    if (pd_req_i)        mode_d = pd_deep_i ? MODE_OFF : MODE_STBY;
    else if (wake_req_i) mode_d = MODE_ON;
  end

  always_comb begin
    tgt = '0;
    case (mode_q)
      MODE_STBY: tgt[DOM_IO] = 1'b1;
      MODE_ON: begin
        tgt[DOM_IO]   = 1'b1;
        tgt[DOM_CORE] = 1'b1;
        tgt[DOM_WR]   = wr_pend_i;
      end
      default: tgt = '0;
    endcase
  end

  pwr_step_sel #(.N(NUM_DOM)) i_step_sel (
    .go_i    (idle),
    .en_i    (en_q),
    .tgt_i   (tgt),
    .en_nxt_o(en_d),
    .load_o  (load)
  );

  pwr_settle_timer #(.CNT_W(CNT_W)) i_settle_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(settle_cyc_i),
    .idle_o    (idle)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_OFF;
      en_q      <= '0;
      cmd_rej_o <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      en_q      <= en_d;
      cmd_rej_o <= cmd_i & ~ready_o;
    end
  end

  assign io_en_o   = en_q[DOM_IO];
  assign core_en_o = en_q[DOM_CORE];
  assign wr_en_o   = en_q[DOM_WR];
  assign ready_o   = (mode_q == MODE_ON) && (en_q == tgt) && idle;

  AST_ONE_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(en_q ^ $past(en_q)) <= 1); // R3
  AST_PREFIX_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_en_o || io_en_o) && (!wr_en_o || core_en_o)); // R4
  AST_READY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (io_en_o && core_en_o && (wr_en_o == wr_pend_i))); // R5
  AST_WR_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> $past(wr_pend_i)); // R6
  AST_DEEP_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == MODE_OFF) |-> ((en_q & ~$past(en_q)) == '0)); // R7
  AST_CHANGE_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q != $past(en_q)) |-> $past(idle)); // R9
  AST_REJECT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rej_o |-> $past(cmd_i && !ready_o)); // R10
endmodule

// File: tb/test_pwr_wake_seq.sv
module test_pwr_wake_seq;
  localparam int CNT_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pd_req_i = 1'b0, pd_deep_i = 1'b0, wake_req_i = 1'b0, wr_pend_i = 1'b0, cmd_i = 1'b0;
  logic [CNT_W-1:0] settle_cyc_i = '0;
  logic io_en_o, core_en_o, wr_en_o, ready_o, cmd_rej_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  pwr_wake_seq #(.CNT_W(CNT_W)) i_pwr_wake_seq (
    .clk_i, .rst_ni, .pd_req_i, .pd_deep_i, .wake_req_i, .wr_pend_i,
    .settle_cyc_i, .cmd_i, .io_en_o, .core_en_o, .wr_en_o, .ready_o, .cmd_rej_o
  );

  always #5 clk_i = ~clk_i;

  function automatic int en_vec();
    return {wr_en_o, core_en_o, io_en_o};
  endfunction

  function automatic int exp_rej(logic c, logic r);
    return int'(c & ~r);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic pulse(logic pd, logic deep, logic wk);
    pd_req_i = pd; pd_deep_i = deep; wake_req_i = wk;
    step();
    pd_req_i = 1'b0; pd_deep_i = 1'b0; wake_req_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    logic p_cmd, p_rdy;
    int   p_en;
    void'($urandom(32'd1234));
    #1;
    chk("R1 enables in reset", en_vec(), 0);
    step(2);
    rst_ni = 1'b1;
    step();
    chk("R1 enables after reset", en_vec(), 0);
    chk("R1 ready after reset", ready_o, 0);
    chk("R1 reject after reset", cmd_rej_o, 0);

    cmd_i = 1'b1; step(); cmd_i = 1'b0;
    chk("R10 reject when not ready", cmd_rej_o, 1);

    // R2 wake from deep power-down, N=3
    settle_cyc_i = 8'd3;
    pulse(1'b0, 1'b0, 1'b1);
    step();
    chk("R2 io first", en_vec(), 3'b001);
    step(3);
    chk("R2 core waits settle", en_vec(), 3'b001);
    step();
    chk("R2 core after N+1", en_vec(), 3'b011);
    chk("R5 ready low while settling", ready_o, 0);
    step(2);
    chk("R2 ready not early", ready_o, 0);
    step();
    chk("R2 ready after settle", ready_o, 1);
    chk("R6 write off without pending", wr_en_o, 0);

    cmd_i = 1'b1; step(); cmd_i = 1'b0;
    chk("R10 no reject when ready", cmd_rej_o, 0);

    // R6 write domain on demand
    wr_pend_i = 1'b1;
    step();
    chk("R6 write on next edge", en_vec(), 3'b111);
    chk("R5 ready low during write settle", ready_o, 0);
    step(2);
    chk("R6 ready not early", ready_o, 0);
    step();
    chk("R6 ready after write settle", ready_o, 1);
    wr_pend_i = 1'b0;
    step();
    chk("R6 write off after pending drops", en_vec(), 3'b011);
    chk("R5 ready back", ready_o, 1);

    // R7 deep power-down in reverse order
    wr_pend_i = 1'b1;
    step(4);
    chk("R6 write back on", en_vec(), 3'b111);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R7 no change on mode edge", en_vec(), 3'b111);
    step();
    chk("R7 write off first", en_vec(), 3'b011);
    step();
    chk("R7 core off second", en_vec(), 3'b001);
    step();
    chk("R7 io off last", en_vec(), 3'b000);
    wr_pend_i = 1'b0;

    // R11 power-down wins over wake
    pulse(1'b1, 1'b1, 1'b1);
    step(3);
    chk("R11 pd wins over wake", en_vec(), 3'b000);

    // R8 light power-down keeps io
    settle_cyc_i = 8'd0;
    pulse(1'b0, 1'b0, 1'b1);
    step(2);
    chk("R2 wake with N=0", ready_o, 1);
    pulse(1'b1, 1'b0, 1'b0);
    step();
    chk("R8 core off", en_vec(), 3'b001);
    step(3);
    chk("R8 io stays on", en_vec(), 3'b001);
    chk("R8 not ready in standby", ready_o, 0);

    // R12 wake from regular standby, N=2
    settle_cyc_i = 8'd2;
    pulse(1'b0, 1'b0, 1'b1);
    step();
    chk("R12 core at next edge", en_vec(), 3'b011);
    chk("R12 ready waits", ready_o, 0);
    step();
    chk("R12 ready not early", ready_o, 0);
    step();
    chk("R12 ready after N+1", ready_o, 1);

    // R9 power-down during wake waits for the running settle window
    pulse(1'b1, 1'b1, 1'b0);
    step(2);
    chk("R7 back to deep", en_vec(), 3'b000);
    settle_cyc_i = 8'd5;
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R9 io on during window", en_vec(), 3'b001);
    step(4);
    chk("R9 io held in window", en_vec(), 3'b001);
    step();
    chk("R9 io held at window end", en_vec(), 3'b001);
    step();
    chk("R9 io off after window", en_vec(), 3'b000);

    // Constrained random phase with per-cycle port checks
    for (int k = 0; k < 4000; k++) begin
      pd_req_i   = ($urandom % 24) == 0;
      pd_deep_i  = $urandom % 2;
      wake_req_i = ($urandom % 8) == 0;
      if (($urandom % 16) == 0) wr_pend_i = ~wr_pend_i;
      cmd_i      = ($urandom % 4) == 0;
      if (($urandom % 64) == 0) settle_cyc_i = CNT_W'($urandom % 4);
      #1;
      p_cmd = cmd_i;
      p_rdy = ready_o;
      p_en  = en_vec();
      if (ready_o)
        chk("R5 ready consistency", {io_en_o, core_en_o, wr_en_o}, {2'b11, wr_pend_i});
      step();
      chk("R10 reject", cmd_rej_o, exp_rej(p_cmd, p_rdy));
      chk("R3 one change", int'($countones(3'(p_en ^ en_vec())) <= 1), 1);
      chk("R4 prefix", int'((!core_en_o || io_en_o) && (!wr_en_o || core_en_o)), 1);
    end

    finish_run();
  end
endmodule